// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Registers

This block keeps the two 16-bit state words of a floating-point unit. The status word holds six sticky exception flags, an error summary bit, four condition code bits, the 3-bit register stack pointer and a busy bit. The control word holds one mask bit per exception, a precision field, a rounding field and an infinity-mode bit. The arithmetic units report each exception as a one-cycle pulse on `excPulse`. A flag that is set stays set until an explicit clear command. The error summary, and the interrupt request driven from it, come only from flags whose mask bit is 0.

A small command port loads the control word, reads either word out through a registered store port, and clears the exceptions. Side inputs let the execution pipeline write the condition codes and the stack pointer and set the busy bit. The control fields are also decoded for the rounding and normalisation logic further down the pipe. They leave the block as the raw precision code, the significand width, a flag for the reserved precision code, the rounding mode and the infinity mode.

Every output comes straight from registers or from combinational logic on registers, so each output is stable for a whole clock cycle.

Top module: `fpu_exc_ctrl`

## Requirements
- R1: After reset, `statusWord` is 0x0000, `controlWord` is 0x037F, and `irqReq` and `storeValid` are 0.
- R2: A 1 on `excPulse[k]` sets status bit k one cycle later. The bit assignment is invalid 0, denormal 1, zero-divide 2, overflow 3, underflow 4 and precision 5. A flag stays set until a clear command takes effect, and a change of mask bits never alters it. Status bit 6 always reads 0.
- R3: Status bit 7 (error summary) and `irqReq` are both 1 exactly when some status bit k in 0..5 is 1 while control bit k is 0. Both follow a change of mask in the same cycle that the control word changes.
- R4: Command code 1 (load) writes `cmdData` into the control word one cycle later. Bit 6 is forced to 1, and bits 7 and 15:13 are forced to 0.
- R5: Command code 2 (store control) or code 3 (store status) raises `storeValid` for one cycle, one cycle after the command. `storeData` then holds the selected word as it was in the command cycle.
- R6: Command code 4 (clear) zeroes flags 0..5 and the busy bit one cycle later. An exception pulse in the same cycle as the clear still sets its flag. A `busySet` in the same cycle as the clear leaves busy set.
- R7: `ccWrEn` loads `ccIn[0]`, `ccIn[1]`, `ccIn[2]` and `ccIn[3]` into status bits 8, 9, 10 and 14. `topWrEn` loads `topIn` into status bits 13:11. `busySet` sets status bit 15. Each takes effect one cycle later.
- R8: `precMode` equals control bits 9:8. `sigBits` is 24 for code 00, 53 for code 10, and 64 for codes 11 and 01. `precReserved` is 1 only for code 01.
- R9: `roundMode` equals control bits 11:10 (00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero). `affineInf` equals control bit 12 (0 projective, 1 affine).
- R10: A command has no effect when `cmdValid` is 0 or when `cmdOp` is 0, 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| excPulse | input | 6 | One-cycle exception events, bit k sets flag k |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code: 1 load, 2 store control, 3 store status, 4 clear |
| cmdData | input | 16 | Control word value for a load |
| ccWrEn | input | 1 | Write enable for the condition codes |
| ccIn | input | 4 | Condition codes, index 0..3 |
| topWrEn | input | 1 | Write enable for the stack pointer |
| topIn | input | 3 | New stack pointer |
| busySet | input | 1 | Sets the busy bit |
| statusWord | output | 16 | Current status word |
| controlWord | output | 16 | Current control word |
| storeValid | output | 1 | Store result valid for one cycle |
| storeData | output | 16 | Stored word |
| irqReq | output | 1 | Interrupt request from unmasked flags |
| precMode | output | 2 | Precision field |
| sigBits | output | 7 | Significand width selected by the precision field |
| precReserved | output | 1 | The precision field holds the reserved code |
| roundMode | output | 2 | Rounding field |
| affineInf | output | 1 | Infinity mode, 1 affine |

## Verification
The embedded assertions check these rules on every cycle:
- each set flag stays set unless a clear comes;
- the summary bit and `irqReq` agree with the unmasked flags;
- the reserved control bits keep their forced values;
- a load lands in the control word;
- a store response follows its command.

The bench's behavioural model is compared on every clock. Only its directed and random scenarios can show the remaining behaviour:
- the priority of a clear against a same-cycle pulse or `busySet`;
- that unused or unstrobed commands leave the words untouched;
- the decoded precision widths for each code;
- the bit placement of the condition codes and the stack pointer.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;
  localparam int EXC_COUNT = 6;
  localparam int WORD_W    = 16;
  localparam int TOP_W     = 3;
  localparam int CC_W      = 4;
  localparam int OP_W      = 3;
  localparam int SIG_W     = 7;

  localparam logic [WORD_W-1:0] CW_RESET    = 16'h037F;
  localparam logic [WORD_W-1:0] CW_KEEP     = 16'h1F3F;
  localparam logic [WORD_W-1:0] CW_FORCE1   = 16'h0040;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 3'd0,
    OP_LOAD_CW = 3'd1,
    OP_STORE_CW = 3'd2,
    OP_STORE_SW = 3'd3,
    OP_CLEAR   = 3'd4
  } fpuOp_e;

  typedef struct packed {
    logic loadCw;
    logic storeCw;
    logic storeSw;
    logic clearExc;
  } fpuStrobes_t;

  function automatic logic [SIG_W-1:0] sigWidth(input logic [1:0] pc);
    case (pc)
      2'b00:   sigWidth = 7'd24;
      2'b10:   sigWidth = 7'd53;
      default: sigWidth = 7'd64;
    endcase
  endfunction
endpackage

// File: rtl/fpu_exc_control.sv
module fpu_exc_control
  import fpu_exc_pkg::*;
(
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  output fpuStrobes_t     strb
);
  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (cmdOp)
        OP_LOAD_CW:  strb.loadCw   = 1'b1;
        OP_STORE_CW: strb.storeCw  = 1'b1;
        OP_STORE_SW: strb.storeSw  = 1'b1;
        OP_CLEAR:    strb.clearExc = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

  // R10: strobes are mutually exclusive and need cmdValid
  always_comb begin
    assert_onehot_strobes_R10: assert ($onehot0(strb));
    assert_valid_gate_R10: assert (cmdValid || (strb == '0));
  end
endmodule

// File: rtl/fpu_exc_datapath.sv
module fpu_exc_datapath
  import fpu_exc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  fpuStrobes_t          strb,
  input  logic [EXC_COUNT-1:0] excPulse,
  input  logic [WORD_W-1:0]    cmdData,
  input  logic                 ccWrEn,
  input  logic [CC_W-1:0]      ccIn,
  input  logic                 topWrEn,
  input  logic [TOP_W-1:0]     topIn,
  input  logic                 busySet,
  output logic [WORD_W-1:0]    statusWord,
  output logic [WORD_W-1:0]    controlWord,
  output logic                 storeValid,
  output logic [WORD_W-1:0]    storeData,
  output logic                 irqReq,
  output logic [1:0]           precMode,
  output logic [SIG_W-1:0]     sigBits,
  output logic                 precReserved,
  output logic [1:0]           roundMode,
  output logic                 affineInf
);
  logic [EXC_COUNT-1:0] excFlags;
  logic [CC_W-1:0]      ccReg;
  logic [TOP_W-1:0]     topReg;
  logic                 busyReg;
  logic [WORD_W-1:0]    ctrlReg;
  logic                 errSummary;

  for (genvar g = 0; g < EXC_COUNT; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) excFlags[g] <= 1'b0;
      else       excFlags[g] <= (excFlags[g] & ~strb.clearExc) | excPulse[g];
    end

    // R2: a set flag survives every cycle without a clear
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
      (excFlags[g] && !strb.clearExc) |=> excFlags[g]);
    // R2: a pulse always sets its flag
    assert_flag_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      excPulse[g] |=> excFlags[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccReg   <= '0;
      topReg  <= '0;
      busyReg <= 1'b0;
      ctrlReg <= CW_RESET;
    end else begin
      if (ccWrEn)  ccReg  <= ccIn;
      if (topWrEn) topReg <= topIn;
      busyReg <= busySet | (busyReg & ~strb.clearExc);
      if (strb.loadCw) ctrlReg <= (cmdData & CW_KEEP) | CW_FORCE1;
    end
  end

  assign errSummary = |(excFlags & ~ctrlReg[EXC_COUNT-1:0]);

  always_comb begin
    statusWord        = '0;
    statusWord[EXC_COUNT-1:0] = excFlags;
    statusWord[7]     = errSummary;
    statusWord[10:8]  = ccReg[2:0];
    statusWord[13:11] = topReg;
    statusWord[14]    = ccReg[3];
    statusWord[15]    = busyReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeValid <= 1'b0;
      storeData  <= '0;
    end else begin
      storeValid <= strb.storeCw | strb.storeSw;
      if (strb.storeCw)      storeData <= ctrlReg;
      else if (strb.storeSw) storeData <= statusWord;
    end
  end

  assign controlWord  = ctrlReg;
  assign irqReq       = errSummary;
  assign precMode     = ctrlReg[9:8];
  assign sigBits      = sigWidth(ctrlReg[9:8]);
  assign precReserved = (ctrlReg[9:8] == 2'b01);
  assign roundMode    = ctrlReg[11:10];
  assign affineInf    = ctrlReg[12];

  // R4: reserved control bits hold their forced values
  assert_cw_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[6] && !ctrlReg[7] && (ctrlReg[15:13] == 3'b000));
  // R4: a load lands in the writable fields
  assert_cw_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCw |=> (ctrlReg[12:8] == $past(cmdData[12:8])) &&
                    (ctrlReg[5:0] == $past(cmdData[5:0])));
  // R5: a store response always follows a store command
  assert_store_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    storeValid |-> $past(strb.storeCw || strb.storeSw));
  // R6: a clear with no new pulse leaves every flag zero
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearExc && (excPulse == '0)) |=> (excFlags == '0));
endmodule

// File: rtl/fpu_exc_ctrl.sv
module fpu_exc_ctrl
  import fpu_exc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  excPulse,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [15:0] cmdData,
  input  logic        ccWrEn,
  input  logic [3:0]  ccIn,
  input  logic        topWrEn,
  input  logic [2:0]  topIn,
  input  logic        busySet,
  output logic [15:0] statusWord,
  output logic [15:0] controlWord,
  output logic        storeValid,
  output logic [15:0] storeData,
  output logic        irqReq,
  output logic [1:0]  precMode,
  output logic [6:0]  sigBits,
  output logic        precReserved,
  output logic [1:0]  roundMode,
  output logic        affineInf
);
  fpuStrobes_t strb;

  fpu_exc_control u_control (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .strb     (strb)
  );

  fpu_exc_datapath u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .excPulse     (excPulse),
    .cmdData      (cmdData),
    .ccWrEn       (ccWrEn),
    .ccIn         (ccIn),
    .topWrEn      (topWrEn),
    .topIn        (topIn),
    .busySet      (busySet),
    .statusWord   (statusWord),
    .controlWord  (controlWord),
    .storeValid   (storeValid),
    .storeData    (storeData),
    .irqReq       (irqReq),
    .precMode     (precMode),
    .sigBits      (sigBits),
    .precReserved (precReserved),
    .roundMode    (roundMode),
    .affineInf    (affineInf)
  );

  // R3: the interrupt request agrees with the summary bit and the unmasked flags
  always_comb begin
    assert_irq_summary_R3: assert (irqReq == statusWord[7]);
    assert_irq_unmasked_R3: assert (!irqReq || ((statusWord[5:0] & ~controlWord[5:0]) != 6'd0));
  end
endmodule

// File: tb/test_fpu_exc_ctrl.sv
module test_fpu_exc_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  excPulse = '0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [15:0] cmdData = '0;
  logic        ccWrEn = 1'b0;
  logic [3:0]  ccIn = '0;
  logic        topWrEn = 1'b0;
  logic [2:0]  topIn = '0;
  logic        busySet = 1'b0;
  logic [15:0] statusWord, controlWord, storeData;
  logic        storeValid, irqReq, precReserved, affineInf;
  logic [1:0]  precMode, roundMode;
  logic [6:0]  sigBits;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpu_exc_ctrl i_fpu_exc_ctrl (
    .clk(clk), .rstN(rstN), .excPulse(excPulse), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .ccWrEn(ccWrEn), .ccIn(ccIn),
    .topWrEn(topWrEn), .topIn(topIn), .busySet(busySet),
    .statusWord(statusWord), .controlWord(controlWord),
    .storeValid(storeValid), .storeData(storeData), .irqReq(irqReq),
    .precMode(precMode), .sigBits(sigBits), .precReserved(precReserved),
    .roundMode(roundMode), .affineInf(affineInf)
  );

  // Behavioural reference state
  logic [5:0]  mFlags;
  logic        mBusy;
  logic [3:0]  mCc;
  logic [2:0]  mTop;
  logic [15:0] mCw;
  logic        mStV;
  logic [15:0] mStD;

  function automatic logic [15:0] modelSw(input logic [5:0] f, input logic b,
      input logic [3:0] c, input logic [2:0] t, input logic [15:0] cw);
    logic es;
    es = 1'b0;
    for (int k = 0; k < 6; k++) if (f[k] && !cw[k]) es = 1'b1;
    return {b, c[3], t, c[2], c[1], c[0], es, 1'b0, f};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlags = '0; mBusy = 0; mCc = '0; mTop = '0; mCw = 16'h037F;
      mStV = 0; mStD = '0;
    end else begin
      logic clr;
      logic [15:0] oldSw;
      oldSw = modelSw(mFlags, mBusy, mCc, mTop, mCw);
      clr = cmdValid && cmdOp == 3'd4;
      mStV = cmdValid && (cmdOp == 3'd2 || cmdOp == 3'd3);
      if (cmdValid && cmdOp == 3'd2) mStD = mCw;
      if (cmdValid && cmdOp == 3'd3) mStD = oldSw;
      mFlags = (clr ? 6'd0 : mFlags) | excPulse;
      mBusy = busySet || (mBusy && !clr);
      if (ccWrEn) mCc = ccIn;
      if (topWrEn) mTop = topIn;
      if (cmdValid && cmdOp == 3'd1) begin
        mCw = cmdData;
        mCw[6] = 1'b1; mCw[7] = 1'b0; mCw[15:13] = 3'b000;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [15:0] sw;
      logic [6:0]  sb;
      sw = modelSw(mFlags, mBusy, mCc, mTop, mCw);
      sb = (mCw[9:8] == 2'b00) ? 7'd24 : (mCw[9:8] == 2'b10) ? 7'd53 : 7'd64;
      check("R2/R7", "statusWord", statusWord, sw);
      check("R3", "irqReq", {15'd0, irqReq}, {15'd0, sw[7]});
      check("R4", "controlWord", controlWord, mCw);
      check("R5", "storeValid", {15'd0, storeValid}, {15'd0, mStV});
      if (mStV) check("R5", "storeData", storeData, mStD);
      check("R8", "precMode", {14'd0, precMode}, {14'd0, mCw[9:8]});
      check("R8", "sigBits", {9'd0, sigBits}, {9'd0, sb});
      check("R8", "precReserved", {15'd0, precReserved}, {15'd0, mCw[9:8] == 2'b01});
      check("R9", "roundMode", {14'd0, roundMode}, {14'd0, mCw[11:10]});
      check("R9", "affineInf", {15'd0, affineInf}, {15'd0, mCw[12]});
    end
  end

  task automatic step(input logic [5:0] e, input logic v, input logic [2:0] op,
                      input logic [15:0] d, input logic bs);
    excPulse = e; cmdValid = v; cmdOp = op; cmdData = d; busySet = bs;
    ccWrEn = 0; topWrEn = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset statusWord", statusWord, 16'h0000);
    check("R1", "reset controlWord", controlWord, 16'h037F);
    check("R1", "reset irq/store", {14'd0, irqReq, storeValid}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R2: each exception alone, all masked
    for (int k = 0; k < 6; k++) step(6'(1 << k), 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R2", "all flags sticky", {10'd0, statusWord[5:0]}, 16'h003F);
    // R3: unmask all, then remask -> flags keep
    step(0, 1, 3'd1, 16'h0000, 0);
    step(0, 0, 0, 0, 0);
    check("R3", "irq unmasked", {15'd0, irqReq}, 16'd1);
    step(0, 1, 3'd1, 16'hFFFF, 0);
    step(0, 0, 0, 0, 0);
    check("R2", "mask change keeps flags", {10'd0, statusWord[5:0]}, 16'h003F);
    // R5 store both words
    step(0, 1, 3'd2, 0, 0);
    step(0, 1, 3'd3, 0, 1);
    // R6: clear with concurrent zero-divide and busySet
    step(6'b000100, 1, 3'd4, 0, 1);
    check("R6", "clear keeps same-cycle pulse", {10'd0, statusWord[5:0]}, 16'h0004);
    check("R6", "busySet wins over clear", {15'd0, statusWord[15]}, 16'd1);
    step(0, 1, 3'd4, 0, 0);
    check("R6", "clear empties flags and busy", {statusWord[15], 9'd0, statusWord[5:0]}, 16'd0);
    // R7: condition codes and stack pointer
    excPulse = 0; cmdValid = 0; ccWrEn = 1; ccIn = 4'b1010; topWrEn = 1; topIn = 3'd5;
    @(negedge clk);
    ccWrEn = 0; topWrEn = 0;
    check("R7", "cc/top placement", statusWord & 16'h7F00, 16'h6A00);
    // R8/R9: all precision and rounding codes
    for (int p = 0; p < 4; p++) begin
      step(0, 1, 3'd1, 16'(p << 8) | 16'(p << 10) | 16'((p & 1) << 12) | 16'h0015, 0);
    end
    step(0, 0, 0, 0, 0);
    // R10: unused codes and unstrobed commands change nothing
    step(6'b100000, 0, 0, 0, 0);
    step(0, 0, 3'd1, 16'h0000, 0);
    step(0, 0, 3'd4, 0, 0);
    for (int op = 5; op < 8; op++) step(0, 1, 3'(op), 16'h0000, 0);
    step(0, 1, 3'd0, 16'h0000, 0);
    check("R10", "control word untouched", controlWord, 16'h1F55);
    check("R10", "flag not cleared", {15'd0, statusWord[5]}, 16'd1);
    // Random traffic
    for (int n = 0; n < 2000; n++) begin
      excPulse = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
      cmdValid = $urandom_range(0, 1) == 1;
      cmdOp = 3'($urandom);
      cmdData = 16'($urandom);
      busySet = $urandom_range(0, 7) == 0;
      ccWrEn = $urandom_range(0, 1) == 1; ccIn = 4'($urandom);
      topWrEn = $urandom_range(0, 1) == 1; topIn = 3'($urandom);
      @(negedge clk);
    end
    done = 1;
    summary();
  end
endmodule